// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of control registers that exist once per hardware unit. The units are arranged as groups, each with several instances, and every copy of a given register answers to the same bus address. A steering selector register, at its own address, names one target unit by group and instance and carries a broadcast bit. A bus write to a replicated address either fans out to every unit or lands in the single targeted unit, depending on that bit. A bus read always returns the copy held by the targeted unit, whatever the broadcast bit says.

Each unit can be absent because it is fused off or because it is power-gated. Two per-unit mask inputs report this and are looked at on every access. An access aimed at an absent unit is terminated: a read returns zero and a targeted write is dropped. Either case raises a one-cycle status pulse. A broadcast write skips absent units and updates only the present ones.

The bus is a plain single-cycle register port. It accepts an access in every cycle and has no back-pressure: read data and the read-valid flag appear on the cycle after the read strobe. A second address writes only the group and instance fields of the selector, so software can re-steer without disturbing the other selector bits.

Top module: `rr_steered_regs`

## Requirements
- R1: After reset the selector reads 0x0001_0000 (group 0, instance 0, broadcast on), every replicated register is zero, and `bus_rvalid` and `access_term` are low.
- R2: Address 8 is the selector. A write stores all 32 bits and a read returns them. The instance field is bits [1:0], the group field is bits [9:8] and the broadcast bit is bit 16 (1 = broadcast).
- R3: A write to address 9 replaces only the selector's group and instance fields with the same bit positions of the write data. Every other selector bit, the broadcast bit included, keeps its value.
- R4: A write to a replicated address (0 to 7) with the broadcast bit set stores the data in every present unit's copy of that register.
- R5: A broadcast write leaves the copies in absent units unchanged, and it does not raise `access_term`.
- R6: A replicated write with the broadcast bit clear updates only the targeted unit's copy. The copies in all other units stay as they were.
- R7: A targeted write to an absent unit changes no register and raises `access_term` for one cycle, on the cycle after the strobe.
- R8: A read of a replicated address returns the targeted unit's copy on `bus_rdata`, with `bus_rvalid` high on the cycle after the strobe, for either setting of the broadcast bit.
- R9: A read of a replicated address aimed at an absent unit returns zero and raises `access_term` alongside `bus_rvalid`.
- R10: The unit index is group*4 + instance. A unit is absent when its bit in `fuse_disable` or in `power_gated` is set, as sampled in the cycle of the access.
- R11: Addresses 10 to 15 are unmapped. Reads return zero, writes change nothing, and neither raises `access_term`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| fuse_disable | input | 16 | Per-unit fused-off mask, bit = group*4+instance |
| power_gated | input | 16 | Per-unit power-gated mask, bit = group*4+instance |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| access_term | output | 1 | One-cycle pulse for a terminated access |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that the presence masks hold steady during the cycle of an access. The stimulus drives one strobe at a time, always followed by an idle cycle. It changes the masks only on the falling clock edge, together with the strobe they belong to. The checks on broadcast skipping and on dropped writes re-enable the absent unit afterwards and read the untouched copy back through the bus.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Selector field placement (software visible, decoded by the bank)
  localparam int SEL_INST_LSB = 0;
  localparam int SEL_GRP_LSB  = 8;
  localparam int SEL_MC_BIT   = 16;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_REPL,
    ACC_SEL,
    ACC_STEER,
    ACC_HOLE
  } acc_kind_e;
endpackage

// File: rtl/rr_steer_sel.sv
module rr_steer_sel
  import rr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int GRP_W  = 2,
  parameter int INST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_steer,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     sel_q,
  output logic [GRP_W-1:0]  grp,
  output logic [INST_W-1:0] inst,
  output logic              mcast
);
  localparam logic [DW-1:0] GRP_MASK  = {{(DW-GRP_W){1'b0}}, {GRP_W{1'b1}}} << SEL_GRP_LSB;
  localparam logic [DW-1:0] INST_MASK = {{(DW-INST_W){1'b0}}, {INST_W{1'b1}}} << SEL_INST_LSB;
  localparam logic [DW-1:0] FIELD_MASK = GRP_MASK | INST_MASK;
  localparam logic [DW-1:0] RESET_VAL  = {{(DW-1){1'b0}}, 1'b1} << SEL_MC_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RESET_VAL;
    end else if (wr_full) begin
      sel_q <= wdata;
    end else if (wr_steer) begin
      sel_q <= (sel_q & ~FIELD_MASK) | (wdata & FIELD_MASK);
    end
  end

  assign grp   = sel_q[SEL_GRP_LSB +: GRP_W];
  assign inst  = sel_q[SEL_INST_LSB +: INST_W];
  assign mcast = sel_q[SEL_MC_BIT];
endmodule

// File: rtl/rr_presence.sv
module rr_presence #(
  parameter int N_GRP  = 4,
  parameter int N_INST = 4,
  parameter int GRP_W  = 2,
  parameter int INST_W = 2,
  parameter int N_UNIT = N_GRP * N_INST,
  parameter int UNIT_W = 4
) (
  input  logic [N_UNIT-1:0] fuse_disable,
  input  logic [N_UNIT-1:0] power_gated,
  input  logic [GRP_W-1:0]  grp,
  input  logic [INST_W-1:0] inst,
  output logic [N_UNIT-1:0] present,
  output logic [UNIT_W-1:0] tgt_unit,
  output logic              tgt_present
);
  localparam int IDX_W = UNIT_W + 1;

  logic [IDX_W-1:0] flat_idx;
  logic             in_range;

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    assign present[u] = ~fuse_disable[u] & ~power_gated[u];
  end

  always_comb begin
    flat_idx = IDX_W'(grp) * IDX_W'(N_INST) + IDX_W'(inst);
    in_range = (grp < GRP_W'(N_GRP - 1) || grp == GRP_W'(N_GRP - 1))
             && (inst < INST_W'(N_INST - 1) || inst == INST_W'(N_INST - 1))
             && (flat_idx < IDX_W'(N_UNIT));
    tgt_unit    = flat_idx[UNIT_W-1:0];
    tgt_present = in_range && present[tgt_unit];
  end
endmodule

// File: rtl/rr_unit_bank.sv
module rr_unit_bank #(
  parameter int N_REG = 8,
  parameter int DW    = 32,
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_word
);
  logic [DW-1:0] copies [N_REG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N_REG; r++) copies[r] <= '0;
    end else if (we) begin
      copies[idx] <= wdata;
    end
  end

  assign rd_word = copies[idx];
endmodule

// File: rtl/rr_steered_regs.sv
module rr_steered_regs
  import rr_pkg::*;
#(
  parameter int N_GRP  = 4,
  parameter int N_INST = 4,
  parameter int N_REG  = 8,
  parameter int DW     = 32,
  parameter int AW     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic [N_GRP*N_INST-1:0]   fuse_disable,
  input  logic [N_GRP*N_INST-1:0]   power_gated,
  output logic [DW-1:0]             bus_rdata,
  output logic                      bus_rvalid,
  output logic                      access_term
);
  localparam int N_UNIT = N_GRP * N_INST;
  localparam int GRP_W  = (N_GRP  > 1) ? $clog2(N_GRP)  : 1;
  localparam int INST_W = (N_INST > 1) ? $clog2(N_INST) : 1;
  localparam int UNIT_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1;
  localparam int REG_W  = (N_REG  > 1) ? $clog2(N_REG)  : 1;
  localparam logic [AW-1:0] SEL_ADDR   = AW'(N_REG);
  localparam logic [AW-1:0] STEER_ADDR = AW'(N_REG + 1);

  acc_kind_e         kind;
  logic [DW-1:0]     sel_q;
  logic [GRP_W-1:0]  grp;
  logic [INST_W-1:0] inst;
  logic              mcast;
  logic [N_UNIT-1:0] present;
  logic [UNIT_W-1:0] tgt_unit;
  logic              tgt_present;
  logic [N_UNIT-1:0] unit_we;
  logic [DW-1:0]     bank_word [N_UNIT];
  logic [REG_W-1:0]  reg_idx;
  logic [DW-1:0]     rdata_d;
  logic              term_d;

  // Address decode
  always_comb begin
    if (!(bus_rd || bus_wr))       kind = ACC_IDLE;
    else if (bus_addr < SEL_ADDR)  kind = ACC_REPL;
    else if (bus_addr == SEL_ADDR) kind = ACC_SEL;
    else if (bus_addr == STEER_ADDR) kind = ACC_STEER;
    else                           kind = ACC_HOLE;
  end

  assign reg_idx = bus_addr[REG_W-1:0];

  rr_steer_sel #(.DW(DW), .GRP_W(GRP_W), .INST_W(INST_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .wr_full  (bus_wr && kind == ACC_SEL),
    .wr_steer (bus_wr && kind == ACC_STEER),
    .wdata    (bus_wdata),
    .sel_q    (sel_q),
    .grp      (grp),
    .inst     (inst),
    .mcast    (mcast)
  );

  rr_presence #(
    .N_GRP(N_GRP), .N_INST(N_INST), .GRP_W(GRP_W), .INST_W(INST_W),
    .N_UNIT(N_UNIT), .UNIT_W(UNIT_W)
  ) u_pres (
    .fuse_disable (fuse_disable),
    .power_gated  (power_gated),
    .grp          (grp),
    .inst         (inst),
    .present      (present),
    .tgt_unit     (tgt_unit),
    .tgt_present  (tgt_present)
  );

  // One bank of copies per unit; broadcast writes reach every present unit
  for (genvar u = 0; u < N_UNIT; u++) begin : g_bank
    assign unit_we[u] = bus_wr && (kind == ACC_REPL) && present[u]
                        && (mcast || tgt_unit == UNIT_W'(u));

    rr_unit_bank #(.N_REG(N_REG), .DW(DW), .REG_W(REG_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (unit_we[u]),
      .idx     (reg_idx),
      .wdata   (bus_wdata),
      .rd_word (bank_word[u])
    );
  end

  // Read data and termination, registered one cycle after the strobe
  always_comb begin
    rdata_d = '0;
    term_d  = 1'b0;
    unique case (kind)
      ACC_REPL: begin
        if (bus_rd && tgt_present) rdata_d = bank_word[tgt_unit];
        term_d = !tgt_present && (bus_rd || (bus_wr && !mcast));
      end
      ACC_SEL, ACC_STEER: begin
        if (bus_rd) rdata_d = sel_q;
      end
      default: begin
        rdata_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      bus_rvalid  <= 1'b0;
      access_term <= 1'b0;
    end else begin
      bus_rdata   <= bus_rd ? rdata_d : '0;
      bus_rvalid  <= bus_rd;
      access_term <= term_d;
    end
  end
endmodule

// File: rtl/rr_steered_regs_chk.sv
module rr_steered_regs_chk
  import rr_pkg::*;
#(
  parameter int N_GRP  = 4,
  parameter int N_INST = 4,
  parameter int N_REG  = 8,
  parameter int DW     = 32,
  parameter int AW     = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [AW-1:0]           bus_addr,
  input logic [DW-1:0]           bus_wdata,
  input logic [N_GRP*N_INST-1:0] fuse_disable,
  input logic [N_GRP*N_INST-1:0] power_gated,
  input logic [DW-1:0]           bus_rdata,
  input logic                    bus_rvalid,
  input logic                    access_term,
  input logic [DW-1:0]           sel_q
);
  localparam int GRP_W  = (N_GRP  > 1) ? $clog2(N_GRP)  : 1;
  localparam int INST_W = (N_INST > 1) ? $clog2(N_INST) : 1;
  localparam int N_UNIT = N_GRP * N_INST;
  localparam int UNIT_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1;
  localparam logic [AW-1:0] SEL_ADDR   = AW'(N_REG);
  localparam logic [AW-1:0] STEER_ADDR = AW'(N_REG + 1);
  localparam logic [DW-1:0] KEEP_MASK =
      ~(({{(DW-GRP_W){1'b0}}, {GRP_W{1'b1}}} << SEL_GRP_LSB)
      | ({{(DW-INST_W){1'b0}}, {INST_W{1'b1}}} << SEL_INST_LSB));

  logic [UNIT_W-1:0] chk_unit;
  assign chk_unit = UNIT_W'(32'(sel_q[SEL_GRP_LSB +: GRP_W]) * N_INST
                    + 32'(sel_q[SEL_INST_LSB +: INST_W]));

  assert_sel_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == SEL_ADDR) |=> sel_q == $past(bus_wdata));

  assert_steer_keeps_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == STEER_ADDR) |=> (sel_q & KEEP_MASK) == $past(sel_q & KEEP_MASK));

  assert_rvalid_follows_rd_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rvalid_needs_rd_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));

  assert_term_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (access_term && bus_rvalid) |-> bus_rdata == '0);

  assert_term_after_access_R7: assert property (@(posedge clk) disable iff (rst)
    access_term |-> $past(bus_rd || bus_wr));

  assert_absent_read_terms_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr < SEL_ADDR && (fuse_disable[chk_unit] || power_gated[chk_unit]))
    |=> access_term);

  assert_hole_no_term_R11: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr > STEER_ADDR) |=> !access_term);
endmodule

bind rr_steered_regs rr_steered_regs_chk #(
  .N_GRP(N_GRP), .N_INST(N_INST), .N_REG(N_REG), .DW(DW), .AW(AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .fuse_disable (fuse_disable),
  .power_gated  (power_gated),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .access_term  (access_term),
  .sel_q        (sel_q)
);

// File: tb/tb_rr_steered_regs.sv
`timescale 1ns/1ps
module tb_rr_steered_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] fuse_disable = '0;
  logic [15:0] power_gated = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        access_term;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  rr_steered_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fuse_disable(fuse_disable), .power_gated(power_gated),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .access_term(access_term)
  );

  // {rd, addr, wdata, fuse, gate, exp_data, exp_term, req}
  localparam int NV = 28;
  localparam logic [105:0] VEC [NV] = '{
    {1'b0, 4'd0,  32'hA0A0_0001, 16'h0002, 16'h0000, 32'h0,          1'b0, 4'd4},  // R4 broadcast, unit1 fused
    {1'b0, 4'd9,  32'h0000_0101, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd3},  // R3 steer g1 i1
    {1'b1, 4'd8,  32'h0,         16'h0000, 16'h0000, 32'h0001_0101,  1'b0, 4'd3},  // R3 broadcast bit kept
    {1'b1, 4'd0,  32'h0,         16'h0000, 16'h0000, 32'hA0A0_0001,  1'b0, 4'd8},  // R8 read in broadcast mode
    {1'b0, 4'd9,  32'h0000_0001, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd3},  // R3 steer unit1
    {1'b1, 4'd0,  32'h0,         16'h0002, 16'h0000, 32'h0,          1'b1, 4'd9},  // R9 fused read
    {1'b1, 4'd0,  32'h0,         16'h0000, 16'h0000, 32'h0,          1'b0, 4'd5},  // R5 unit1 skipped
    {1'b0, 4'd8,  32'h0000_0302, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd2},  // R2 targeted g3 i2
    {1'b1, 4'd8,  32'h0,         16'h0000, 16'h0000, 32'h0000_0302,  1'b0, 4'd2},  // R2
    {1'b0, 4'd1,  32'h1111_2222, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd6},  // R6 write unit14
    {1'b1, 4'd1,  32'h0,         16'h0000, 16'h0000, 32'h1111_2222,  1'b0, 4'd6},  // R6
    {1'b0, 4'd9,  32'h0000_0303, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd3},  // R3 steer unit15
    {1'b1, 4'd1,  32'h0,         16'h0000, 16'h0000, 32'h0,          1'b0, 4'd6},  // R6 unit15 untouched
    {1'b0, 4'd1,  32'hDEAD_BEEF, 16'h0000, 16'h8000, 32'h0,          1'b1, 4'd7},  // R7 gated write dropped
    {1'b1, 4'd1,  32'h0,         16'h0000, 16'h0000, 32'h0,          1'b0, 4'd7},  // R7 still zero
    {1'b1, 4'd1,  32'h0,         16'h0000, 16'h8000, 32'h0,          1'b1, 4'd10}, // R10 gated read
    {1'b0, 4'd12, 32'h0000_0055, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd11}, // R11 hole write
    {1'b1, 4'd12, 32'h0,         16'h0000, 16'h0000, 32'h0,          1'b0, 4'd11}, // R11 hole read
    {1'b1, 4'd8,  32'h0,         16'h0000, 16'h0000, 32'h0000_0303,  1'b0, 4'd11}, // R11 selector intact
    {1'b0, 4'd8,  32'hFFFF_FFFF, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd2},  // R2 all ones
    {1'b0, 4'd9,  32'h0000_0000, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd3},  // R3 clear fields only
    {1'b1, 4'd8,  32'h0,         16'h0000, 16'h0000, 32'hFFFF_FCFC,  1'b0, 4'd3},  // R3
    {1'b1, 4'd0,  32'h0,         16'h0000, 16'h0000, 32'hA0A0_0001,  1'b0, 4'd4},  // R4 unit0 copy
    {1'b0, 4'd2,  32'h7777_7777, 16'h0000, 16'h0001, 32'h0,          1'b0, 4'd5},  // R5 broadcast, unit0 gated
    {1'b1, 4'd2,  32'h0,         16'h0000, 16'h0001, 32'h0,          1'b1, 4'd10}, // R10 gated unit0
    {1'b1, 4'd2,  32'h0,         16'h0000, 16'h0000, 32'h0,          1'b0, 4'd5},  // R5 unit0 kept zero
    {1'b0, 4'd9,  32'h0000_0100, 16'h0000, 16'h0000, 32'h0,          1'b0, 4'd3},  // R3 steer unit4
    {1'b1, 4'd2,  32'h0,         16'h0000, 16'h0000, 32'h7777_7777,  1'b0, 4'd4}   // R4 unit4 got it
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit rd, input logic [3:0] a, input logic [31:0] d,
                        input logic [15:0] fz, input logic [15:0] pg);
    @(negedge clk);
    bus_rd = rd; bus_wr = !rd; bus_addr = a; bus_wdata = d;
    fuse_disable = fz; power_gated = pg;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; fuse_disable = '0; power_gated = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, {31'd0, bus_rvalid}, 32'd0);
    check(1, {31'd0, access_term}, 32'd0);
    access(1'b1, 4'd8, '0, '0, '0);
    check(1, bus_rdata, 32'h0001_0000);
    access(1'b1, 4'd5, '0, '0, '0);
    check(1, bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VEC[i];
      access(v[105], v[104:101], v[100:69], v[68:53], v[52:37]);
      if (v[105]) begin
        check(int'(v[3:0]), bus_rdata, v[36:5]);
        check(8, {31'd0, bus_rvalid}, 32'd1);  // R8 valid one cycle later
      end
      check(int'(v[3:0]), {31'd0, access_term}, {31'd0, v[4]});
    end

    // R8 valid drops when idle; term is a single pulse (R7)
    @(negedge clk);
    check(8, {31'd0, bus_rvalid}, 32'd0);
    check(7, {31'd0, access_term}, 32'd0);

    // R1 reset mid-run clears selector and copies
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(1'b1, 4'd8, '0, '0, '0);
    check(1, bus_rdata, 32'h0001_0000);
    access(1'b1, 4'd0, '0, '0, '0);
    check(1, bus_rdata, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule